// File: doc/BRIEF.md
# Display Timing Counters with Software Hold

This block produces the raster timing of a display controller: a horizontal character counter, a vertical line counter, display-enable windows and sync pulses for both axes. All totals, display widths and sync positions come from configuration inputs, so one instance serves any mode whose counts fit the chosen widths.

The block also watches writes to the sequencer register port and holds the horizontal counter from software. A write to sequencer index 07h sets a hold latch, and the data written does not matter, so the port carries no data. While the latch is set, the horizontal count reads zero. A later write to any index from 0 to 6 clears the latch. The vertical counter steps only when horizontal display enable falls, so a held line also stalls the frame. If the hold is placed while vertical sync is active, the vertical count is also brought to zero. Releasing the hold then starts both axes together from the top-left corner, in step with the software write.

Top module: `scan_timer`

## Requirements
- R1: While `rstN` is low, `hCount` and `vCount` are 0 and the hold latch is clear.
- R2: With the hold clear, `hCount` rises by one on each clock edge and goes from `hTotal-1` back to 0, so a line lasts `hTotal` cycles.
- R3: `hDe` is high exactly when `hCount < hDisp`. `hSync` is high exactly when `hSyncStart <= hCount < hSyncEnd`.
- R4: `vCount` rises by one on the clock edge that ends a cycle in which `hDe` is low and was high in the previous cycle. It goes from `vTotal-1` back to 0.
- R5: `vDe` is high exactly when `vCount < vDisp`. `vSync` is high exactly when `vSyncStart <= vCount < vSyncEnd`.
- R6: A write (`regWrEn` high) with `regIndex` equal to 7 sets the hold latch at that clock edge. From the next cycle on, `hCount` reads 0 for as long as the latch stays set.
- R7: A write with `regIndex` from 0 to 6 clears the latch at that clock edge. `hCount` reads 0 in the following cycle and 1 in the cycle after that.
- R8: A write with `regIndex` above 7 leaves the latch unchanged. Counting or holding carries on exactly as it would without the write.
- R9: While the latch is set and `vSync` is low, `vCount` does not change.
- R10: While the latch is set and `vSync` is high, `vCount` becomes 0 at the next edge. After release, both counters restart together from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Sequencer register write strobe, one per cycle |
| regIndex | input | IDX_W | Sequencer register index of the write |
| hTotal | input | HW | Characters per line |
| hDisp | input | HW | Displayed characters per line |
| hSyncStart | input | HW | First character count with horizontal sync |
| hSyncEnd | input | HW | First character count after horizontal sync |
| vTotal | input | VW | Lines per frame |
| vDisp | input | VW | Displayed lines per frame |
| vSyncStart | input | VW | First line with vertical sync |
| vSyncEnd | input | VW | First line after vertical sync |
| hCount | output | HW | Horizontal character count (0 while held) |
| vCount | output | VW | Vertical line count |
| hDe | output | 1 | Horizontal display enable |
| vDe | output | 1 | Vertical display enable |
| hSync | output | 1 | Horizontal sync |
| vSync | output | 1 | Vertical sync |

## Verification
The hardest case to reach is a hold placed while vertical sync is active, because it needs the bench to know where the frame is when it issues the write. The bench runs a cycle-level reference model next to the design. It advances the model until the model shows vertical sync, then issues the index-7 write and checks that `vCount` collapses to 0 and that both axes restart together on release. A sweep writes every index from 0 to 255 with idle gaps between writes, and a mid-display hold mixes in writes to high indices, so set, clear and ignore are all seen against a running raster on two configurations.

// File: rtl/scan_timer_pkg.sv
package scan_timer_pkg;

  // Sequencer index whose write places the horizontal hold
  localparam int SEQ_HOLD_IDX = 7;

  // Strobes from control to datapath
  typedef struct packed {
    logic holdH;   // force horizontal counter to zero
    logic vStep;   // advance vertical counter one line
    logic vClear;  // clear vertical counter (held during sync)
  } seqStrobe_t;

endpackage

// File: rtl/scan_timer_axis.sv
module scan_timer_axis #(
  parameter int W        = 8,
  parameter bit GATE_OUT = 1'b0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         advance,
  input  logic         clear,
  input  logic [W-1:0] total,
  input  logic [W-1:0] dispEnd,
  input  logic [W-1:0] syncStart,
  input  logic [W-1:0] syncEnd,
  output logic [W-1:0] count,
  output logic         de,
  output logic         sync
);

  logic [W-1:0] cntQ;
  logic [W-1:0] lastVal;
  logic         atEnd;

  assign lastVal = total - W'(1);
  assign atEnd   = (cntQ >= lastVal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (clear) begin
      cntQ <= '0;
    end else if (advance) begin
      cntQ <= atEnd ? '0 : cntQ + W'(1);
    end
  end

  generate
    if (GATE_OUT) begin : g_gated
      always_comb count = clear ? '0 : cntQ;
    end else begin : g_plain
      always_comb count = cntQ;
    end
  endgenerate

  assign de   = (count < dispEnd);
  assign sync = (count >= syncStart) && (count < syncEnd);

endmodule

// File: rtl/scan_timer_ctrl.sv
module scan_timer_ctrl
  import scan_timer_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [IDX_W-1:0] regIndex,
  input  logic             hDe,
  input  logic             vSync,
  output seqStrobe_t       strobe
);

  localparam logic [IDX_W-1:0] HOLD_IDX = IDX_W'(SEQ_HOLD_IDX);

  logic holdQ;
  logic hDeQ;
  logic wrHold;
  logic wrRelease;

  assign wrHold    = regWrEn && (regIndex == HOLD_IDX);
  assign wrRelease = regWrEn && (regIndex <  HOLD_IDX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdQ <= 1'b0;
    end else if (wrHold) begin
      holdQ <= 1'b1;
    end else if (wrRelease) begin
      holdQ <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hDeQ <= 1'b0;
    end else begin
      hDeQ <= hDe;
    end
  end

  always_comb begin
    strobe.holdH  = holdQ;
    strobe.vStep  = hDeQ && !hDe;
    strobe.vClear = holdQ && vSync;
  end

endmodule

// File: rtl/scan_timer_dp.sv
module scan_timer_dp
  import scan_timer_pkg::*;
#(
  parameter int HW = 8,
  parameter int VW = 10
) (
  input  logic          clk,
  input  logic          rstN,
  input  seqStrobe_t    strobe,
  input  logic [HW-1:0] hTotal,
  input  logic [HW-1:0] hDisp,
  input  logic [HW-1:0] hSyncStart,
  input  logic [HW-1:0] hSyncEnd,
  input  logic [VW-1:0] vTotal,
  input  logic [VW-1:0] vDisp,
  input  logic [VW-1:0] vSyncStart,
  input  logic [VW-1:0] vSyncEnd,
  output logic [HW-1:0] hCount,
  output logic [VW-1:0] vCount,
  output logic          hDe,
  output logic          vDe,
  output logic          hSync,
  output logic          vSync
);

  scan_timer_axis #(.W(HW), .GATE_OUT(1'b1)) u_hAxis (
    .clk       (clk),
    .rstN      (rstN),
    .advance   (1'b1),
    .clear     (strobe.holdH),
    .total     (hTotal),
    .dispEnd   (hDisp),
    .syncStart (hSyncStart),
    .syncEnd   (hSyncEnd),
    .count     (hCount),
    .de        (hDe),
    .sync      (hSync)
  );

  scan_timer_axis #(.W(VW), .GATE_OUT(1'b0)) u_vAxis (
    .clk       (clk),
    .rstN      (rstN),
    .advance   (strobe.vStep),
    .clear     (strobe.vClear),
    .total     (vTotal),
    .dispEnd   (vDisp),
    .syncStart (vSyncStart),
    .syncEnd   (vSyncEnd),
    .count     (vCount),
    .de        (vDe),
    .sync      (vSync)
  );

endmodule

// File: rtl/scan_timer.sv
module scan_timer
  import scan_timer_pkg::*;
#(
  parameter int HW    = 8,
  parameter int VW    = 10,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [IDX_W-1:0] regIndex,
  input  logic [HW-1:0]    hTotal,
  input  logic [HW-1:0]    hDisp,
  input  logic [HW-1:0]    hSyncStart,
  input  logic [HW-1:0]    hSyncEnd,
  input  logic [VW-1:0]    vTotal,
  input  logic [VW-1:0]    vDisp,
  input  logic [VW-1:0]    vSyncStart,
  input  logic [VW-1:0]    vSyncEnd,
  output logic [HW-1:0]    hCount,
  output logic [VW-1:0]    vCount,
  output logic             hDe,
  output logic             vDe,
  output logic             hSync,
  output logic             vSync
);

  seqStrobe_t strobe;

  scan_timer_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regWrEn  (regWrEn),
    .regIndex (regIndex),
    .hDe      (hDe),
    .vSync    (vSync),
    .strobe   (strobe)
  );

  scan_timer_dp #(.HW(HW), .VW(VW)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .hTotal     (hTotal),
    .hDisp      (hDisp),
    .hSyncStart (hSyncStart),
    .hSyncEnd   (hSyncEnd),
    .vTotal     (vTotal),
    .vDisp      (vDisp),
    .vSyncStart (vSyncStart),
    .vSyncEnd   (vSyncEnd),
    .hCount     (hCount),
    .vCount     (vCount),
    .hDe        (hDe),
    .vDe        (vDe),
    .hSync      (hSync),
    .vSync      (vSync)
  );

endmodule

// File: rtl/scan_timer_chk.sv
module scan_timer_chk #(
  parameter int HW    = 8,
  parameter int VW    = 10,
  parameter int IDX_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             regWrEn,
  input logic [IDX_W-1:0] regIndex,
  input logic [HW-1:0]    hTotal,
  input logic [HW-1:0]    hCount,
  input logic [VW-1:0]    vCount,
  input logic             vSync,
  input logic             held
);

  localparam logic [IDX_W-1:0] IDX7 = IDX_W'(7);

  logic wrSet, wrClr, wrHigh;
  assign wrSet  = regWrEn && (regIndex == IDX7);
  assign wrClr  = regWrEn && (regIndex <  IDX7);
  assign wrHigh = regWrEn && (regIndex >  IDX7);

  AST_RESET_CLEAR: assert property (@(posedge clk) !rstN |-> (hCount == '0 && vCount == '0)); // R1

  AST_H_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (hTotal != '0) |-> (hCount < hTotal)); // R2

  AST_H_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    (!held && !wrSet && hTotal > HW'(1) && hCount < hTotal - HW'(1))
      |=> (hCount == $past(hCount) + HW'(1))); // R2

  AST_HOLD_SET: assert property (@(posedge clk) disable iff (!rstN)
    wrSet |=> (held && hCount == '0)); // R6

  AST_HELD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    held |-> (hCount == '0)); // R6

  AST_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    wrClr |=> !held); // R7

  AST_HIGH_IDX_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    wrHigh |=> (held == $past(held))); // R8

  AST_V_STALL: assert property (@(posedge clk) disable iff (!rstN)
    (held && !vSync) |=> $stable(vCount)); // R9

  AST_V_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (held && vSync) |=> (vCount == '0)); // R10

endmodule

bind scan_timer scan_timer_chk #(.HW(HW), .VW(VW), .IDX_W(IDX_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .regWrEn  (regWrEn),
  .regIndex (regIndex),
  .hTotal   (hTotal),
  .hCount   (hCount),
  .vCount   (vCount),
  .vSync    (vSync),
  .held     (strobe.holdH)
);

// File: tb/scan_timer_test.sv
module scan_timer_test;

  localparam int CLK_PERIOD = 10;
  localparam int HW = 8;
  localparam int VW = 10;
  localparam int IDX_W = 8;
  localparam int WATCHDOG = 150000;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             regWrEn = 1'b0;
  logic [IDX_W-1:0] regIndex = '0;
  logic [HW-1:0]    hTotal, hDisp, hSyncStart, hSyncEnd;
  logic [VW-1:0]    vTotal, vDisp, vSyncStart, vSyncEnd;
  logic [HW-1:0]    hCount;
  logic [VW-1:0]    vCount;
  logic             hDe, vDe, hSync, vSync;

  always #(CLK_PERIOD/2) clk = ~clk;

  scan_timer #(.HW(HW), .VW(VW), .IDX_W(IDX_W)) uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regIndex(regIndex),
    .hTotal(hTotal), .hDisp(hDisp), .hSyncStart(hSyncStart), .hSyncEnd(hSyncEnd),
    .vTotal(vTotal), .vDisp(vDisp), .vSyncStart(vSyncStart), .vSyncEnd(vSyncEnd),
    .hCount(hCount), .vCount(vCount), .hDe(hDe), .vDe(vDe), .hSync(hSync), .vSync(vSync)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  // reference model state
  int  mH, mV;
  bit  mHold, mDePrev;
  int  cHT, cHD, cHSS, cHSE, cVT, cVD, cVSS, cVSE;

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  function automatic int mHOut();
    return mHold ? 0 : mH;
  endfunction

  function automatic bit mVSync();
    return (mV >= cVSS) && (mV < cVSE);
  endfunction

  task automatic compareAll(input string hTag, input string vTag);
    int h;
    h = mHOut();
    chk(hTag, int'(hCount), h);
    chk(vTag, int'(vCount), mV);
    chk("R3 hDe", int'(hDe), int'(h < cHD));
    chk("R3 hSync", int'(hSync), int'((h >= cHSS) && (h < cHSE)));
    chk("R5 vDe", int'(vDe), int'(mV < cVD));
    chk("R5 vSync", int'(vSync), int'(mVSync()));
  endtask

  // one clock: drive at negedge, advance model at edge, compare at next negedge
  task automatic step(input bit we, input int idx);
    int  h;
    bit  de, vStep, vClr;
    regWrEn  = we;
    regIndex = IDX_W'(idx);
    @(posedge clk);
    h     = mHOut();
    de    = (h < cHD);
    vStep = mDePrev && !de;
    vClr  = mHold && mVSync();
    mDePrev = de;
    if (mHold) mH = 0;
    else mH = (mH >= cHT - 1) ? 0 : mH + 1;
    if (vClr) mV = 0;
    else if (vStep) mV = (mV >= cVT - 1) ? 0 : mV + 1;
    if (we && idx == 7) mHold = 1'b1;
    else if (we && idx < 7) mHold = 1'b0;
    @(negedge clk);
    regWrEn = 1'b0;
    compareAll(mHold ? "R6 hCount" : "R2 hCount", mHold ? "R9 vCount" : "R4 vCount");
  endtask

  task automatic applyConfig(input int sel);
    if (sel == 0) begin
      cHT = 10; cHD = 6; cHSS = 7; cHSE = 9;
      cVT = 6;  cVD = 4; cVSS = 4; cVSE = 5;
    end else begin
      cHT = 7;  cHD = 3; cHSS = 4; cHSE = 6;
      cVT = 5;  cVD = 2; cVSS = 3; cVSE = 5;
    end
    hTotal = HW'(cHT); hDisp = HW'(cHD); hSyncStart = HW'(cHSS); hSyncEnd = HW'(cHSE);
    vTotal = VW'(cVT); vDisp = VW'(cVD); vSyncStart = VW'(cVSS); vSyncEnd = VW'(cVSE);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    nFails++;
    $display("FAIL R1 watchdog: actual=%0d cycles expected<%0d", WATCHDOG, WATCHDOG);
    finishRun();
  end

  initial begin
    for (int cfg = 0; cfg < 2; cfg++) begin
      applyConfig(cfg);
      @(negedge clk);
      rstN = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1 hCount", int'(hCount), 0);
      chk("R1 vCount", int'(vCount), 0);
      mH = 0; mV = 0; mHold = 1'b0; mDePrev = 1'b0;
      rstN = 1'b1;

      // free run, horizontal count checked arithmetically
      for (int k = 0; k < 3 * cHT * cVT; k++) begin
        step(1'b0, 0);
        chk("R2 arith", int'(hCount), (k + 1) % cHT);
      end

      // hold placed mid-display, with ignored high-index writes
      while (!(mV == 1 && mH == cHD + 1)) step(1'b0, 0);
      step(1'b1, 7);
      chk("R6 held", int'(hCount), 0);
      for (int k = 0; k < 25; k++) begin
        if (k == 5)       step(1'b1, 8);
        else if (k == 12) step(1'b1, 255);
        else              step(1'b0, 0);
      end
      chk("R9 frozen", int'(vCount), 1);
      step(1'b1, 3);
      chk("R7 zero", int'(hCount), 0);
      step(1'b0, 0);
      chk("R7 one", int'(hCount), 1);
      repeat (2 * cHT) step(1'b0, 0);

      // hold placed during vertical sync
      while (!mVSync()) step(1'b0, 0);
      step(1'b1, 7);
      for (int k = 0; k < 20; k++) step(1'b0, 0);
      chk("R10 vZero", int'(vCount), 0);
      chk("R10 hZero", int'(hCount), 0);
      step(1'b1, 0);
      chk("R10 restartH", int'(hCount), 0);
      chk("R10 restartV", int'(vCount), 0);
      repeat (cHT * cVT) step(1'b0, 0);

      // sweep every index
      for (int i = 0; i < 256; i++) begin
        step(1'b1, i);
        if (i > 7) chk("R8 ignored", int'(hCount), mHOut());
        repeat (3) step(1'b0, 0);
      end
      step(1'b1, 6);
      repeat (2 * cHT * cVT) step(1'b0, 0);
    end
    finishRun();
  end

endmodule